// File: doc/BRIEF.md
# SPI Target Port with Buffered Receive Flags

This block is the device side of a four-wire SPI link. An external master drives the serial clock, select and master-out line. The block returns a preloaded word on the master-in line and collects the master's word at the same time, so each word frame swaps contents between the two ends. All four clock polarity and phase combinations are supported. Two word lengths are available, a short one and a long one, which default to 8 and 16 bits. The serial pins are brought into the system clock domain through two-flop synchronizers, and every SCK edge is found there. The system clock must run at least four times faster than SCK.

On the system side, the word to send is handed over through a valid/ready holding register. `tx_ready` is high while the register is empty. A word is taken on any cycle where `tx_valid` and `tx_ready` are both high. The holding register drains when a word frame starts. Received words come out through a one-entry buffer. `rx_valid` marks the buffer full and stays high until a cycle with `rx_ready` high. The serial master cannot be held off, so a word that completes into a full buffer is lost and raises a sticky overrun flag. A sticky interrupt flag is raised on every completed word and is cleared by `irq_clr`. Tri-stating the master-in line is left to the pad, which `spi_miso_oe` drives.

Top module: `spi_target_port`

## Requirements
- R1: Over one word frame, the bits on `spi_miso` are the word accepted for that frame, and the word delivered on `rx_data` is the master's word. For example, the device sending 0x55 while the master sends 0xAA delivers 0xAA.
- R2: `spi_miso` carries the most significant bit of the word first. Each sampled `spi_mosi` bit enters at bit 0 of the word being collected, and earlier bits move one place up.
- R3: `cfg_cpol` gives the SCK idle level (0 = low, 1 = high). With `cfg_cpha`=0, data is sampled on the first edge of each bit and changes on the second. With `cfg_cpha`=1, it changes on the first edge and is sampled on the second. All four combinations exchange words correctly.
- R4: `cfg_wide`=0 selects 8-bit words and `cfg_wide`=1 selects 16-bit words. A short word is sent from `tx_data[7:0]` and delivered on `rx_data` with the upper byte zero.
- R5: When the last bit of a word is sampled, the word is written to `rx_data`, and `rx_valid` and `irq` go high. `rx_valid` falls after a cycle with `rx_ready` high. `irq` stays high until `irq_clr`.
- R6: While `spi_ss_n` is high, SCK and MOSI activity changes no flag and shifts nothing.
- R7: Raising `spi_ss_n` in the middle of a word discards the partial word without setting any flag. The next frame starts again from bit 0.
- R8: With `cfg_cpha`=0, the holding word is taken and its first bit appears on `spi_miso` when select asserts. With `cfg_cpha`=1, the word is taken on the first SCK edge.
- R9: `spi_miso_oe` is high only while select is asserted, and it is 0 after select is released.
- R10: A word that completes while `rx_valid` is high sets `overrun` and leaves `rx_data` unchanged. `irq_clr` clears `overrun`.
- R11: `tx_ready` is low while the holding register is full. Words sent back to back within one select period use the holding word of each new frame. A frame that starts with the holding register empty sends all zeros.
- R12: After reset, `rx_valid`, `irq`, `overrun` and `spi_miso_oe` are 0, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on first edge, 1: sample on second edge |
| cfg_wide | input | 1 | 0: short word, 1: long word |
| spi_sck | input | 1 | Serial clock from master |
| spi_ss_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Drive enable for the master-in pad |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | 16 | Transmit word |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Consumer takes the buffered word |
| rx_data | output | 16 | Received word |
| irq | output | 1 | Sticky word-complete flag |
| irq_clr | input | 1 | Clears `irq` and `overrun` |
| overrun | output | 1 | Sticky lost-word flag |

## Verification
The assertions assume that `cfg_cpol`, `cfg_cpha` and `cfg_wide` stay constant while select is asserted. The bit-count bound is measured against the live width setting, so this matters. The stimulus changes the configuration only with select high, and then idles SCK at the new polarity before selecting again. It keeps each SCK half period at four system cycles. This ratio lets every synchronized edge settle before the next one and before the master model samples `spi_miso`.

// File: rtl/spi_tp_pkg.sv
package spi_tp_pkg;
  localparam int SPI_TP_SYNC_STAGES = 2;

  typedef struct packed {
    logic active;  // select asserted (synchronized)
    logic start;   // select just asserted
    logic sample;  // capture edge for the current mode
    logic shift;   // launch edge for the current mode
  } spi_tp_evt_t;

  function automatic logic [15:0] spi_tp_low_mask(input int unsigned bits);
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = (i < bits);
    return m;
  endfunction
endpackage

// File: rtl/spi_tp_sync.sv
module spi_tp_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
        else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_tp_edge.sv
module spi_tp_edge
  import spi_tp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpol,
  input  logic        cpha,
  input  logic        sck_s,
  input  logic        ss_n_s,
  output spi_tp_evt_t evt
);
  logic sck_d, ss_n_d;
  logic rise, fall, lead, trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      ss_n_d <= 1'b1;
    end else begin
      sck_d  <= sck_s;
      ss_n_d <= ss_n_s;
    end
  end

  always_comb begin
    rise  = sck_s & ~sck_d;
    fall  = ~sck_s & sck_d;
    lead  = cpol ? fall : rise;
    trail = cpol ? rise : fall;
    evt.active = ~ss_n_s;
    evt.start  = ~ss_n_s & ss_n_d;
    evt.sample = cpha ? trail : lead;
    evt.shift  = cpha ? lead : trail;
  end
endmodule

// File: rtl/spi_tp_shifter.sv
module spi_tp_shifter
  import spi_tp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SHORT_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  logic              wide,
  input  spi_tp_evt_t       evt,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] ld_word,
  output logic              load_req,
  output logic              done,
  output logic [DATA_W-1:0] done_word,
  output logic              miso_bit,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);
  localparam logic [DATA_W-1:0] SHORT_MASK = {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next;
  logic [CNT_W-1:0]  last_idx;
  logic              at_boundary;

  always_comb begin
    last_idx    = wide ? LAST_LONG : LAST_SHORT;
    at_boundary = (bit_cnt == '0);
    load_req    = evt.active & ((evt.start & ~cpha) | (evt.shift & at_boundary));
    rx_next     = {rx_sh[DATA_W-2:0], mosi_s};
    done        = evt.active & evt.sample & (bit_cnt == last_idx);
    done_word   = wide ? rx_next : (rx_next & SHORT_MASK);
    miso_bit    = wide ? tx_sh[DATA_W-1] : tx_sh[SHORT_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_cnt <= '0;
    end else if (!evt.active) begin
      rx_sh   <= '0;
      bit_cnt <= '0;
    end else begin
      if (load_req)       tx_sh <= ld_word;
      else if (evt.shift) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      if (evt.sample) begin
        rx_sh   <= rx_next;
        bit_cnt <= (bit_cnt == last_idx) ? '0 : bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_tp_sysbuf.sv
module spi_tp_sysbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic              done,
  input  logic [DATA_W-1:0] done_word,
  output logic [DATA_W-1:0] ld_word,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq,
  input  logic              irq_clr,
  output logic              overrun
);
  logic [DATA_W-1:0] hold;
  logic              hold_full, accept, pop;

  always_comb begin
    tx_ready = ~hold_full;
    accept   = tx_valid & ~hold_full;
    pop      = rx_valid & rx_ready;
    ld_word  = hold_full ? hold : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (accept) begin
      hold      <= tx_data;
      hold_full <= 1'b1;
    end else if (load_req) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      irq      <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (done && rx_valid && !pop) begin
        overrun <= 1'b1;
      end else if (done) begin
        rx_data  <= done_word;
        rx_valid <= 1'b1;
      end else if (pop) begin
        rx_valid <= 1'b0;
      end
      if (done)         irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (irq_clr && !(done && rx_valid && !pop)) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
  import spi_tp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_wide,
  input  logic              spi_sck,
  input  logic              spi_ss_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq,
  input  logic              irq_clr,
  output logic              overrun
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [2:0]        pins_raw, pins_s;
  spi_tp_evt_t       evt;
  logic              sel_active;
  logic              load_req, word_done, miso_bit;
  logic [DATA_W-1:0] done_word, ld_word;
  logic [CNT_W-1:0]  bit_cnt;

  assign pins_raw = {spi_sck, spi_ss_n, spi_mosi};

  spi_tp_sync #(
    .WIDTH(3), .STAGES(SPI_TP_SYNC_STAGES), .RST_VAL(3'b010)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  spi_tp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .sck_s(pins_s[2]), .ss_n_s(pins_s[1]), .evt(evt)
  );

  spi_tp_shifter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cpha(cfg_cpha), .wide(cfg_wide), .evt(evt),
    .mosi_s(pins_s[0]), .ld_word(ld_word), .load_req(load_req),
    .done(word_done), .done_word(done_word), .miso_bit(miso_bit), .bit_cnt(bit_cnt)
  );

  spi_tp_sysbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .done(word_done),
    .done_word(done_word), .ld_word(ld_word), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq), .irq_clr(irq_clr),
    .overrun(overrun)
  );

  assign sel_active  = evt.active;
  assign spi_miso_oe = sel_active;
  assign spi_miso    = sel_active & miso_bit;
endmodule

// File: rtl/spi_tp_checker.sv
module spi_tp_checker #(
  parameter int DATA_W = 16,
  parameter int SHORT_W = 8,
  parameter int CNT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wide,
  input logic              sel_active,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              irq,
  input logic              irq_clr,
  input logic              overrun
);
  a_r5_irq_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> irq);

  a_r10_keep_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(rx_data));

  a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !irq_clr) |=> overrun);

  a_r11_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |=> (bit_cnt == '0));

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sel_active |-> (32'(bit_cnt) < (cfg_wide ? DATA_W : SHORT_W)));
endmodule

bind spi_target_port spi_tp_checker #(
  .DATA_W(DATA_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .sel_active(sel_active),
  .bit_cnt(bit_cnt), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .irq(irq), .irq_clr(irq_clr), .overrun(overrun)
);

// File: tb/spi_target_port_tb.sv
module spi_target_port_tb_top;
  localparam int H = 4;  // SCK half period in system cycles

  typedef struct packed {
    logic cpol, cpha, wide;
    logic [15:0] stx, mtx, exp_miso, exp_rx;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 1'b0, 16'h0055, 16'h00AA, 16'h0055, 16'h00AA},
    '{1'b0, 1'b1, 1'b0, 16'h00C3, 16'h003C, 16'h00C3, 16'h003C},
    '{1'b1, 1'b0, 1'b0, 16'h0081, 16'h007E, 16'h0081, 16'h007E},
    '{1'b1, 1'b1, 1'b0, 16'h00F0, 16'h000F, 16'h00F0, 16'h000F},
    '{1'b0, 1'b0, 1'b1, 16'hA5C3, 16'h1234, 16'hA5C3, 16'h1234},
    '{1'b0, 1'b1, 1'b1, 16'h8001, 16'hFFFE, 16'h8001, 16'hFFFE},
    '{1'b1, 1'b0, 1'b1, 16'h0F0F, 16'hBEEF, 16'h0F0F, 16'hBEEF},
    '{1'b1, 1'b1, 1'b1, 16'h1357, 16'hCAFE, 16'h1357, 16'hCAFE},
    '{1'b0, 1'b0, 1'b0, 16'h12AB, 16'h77C4, 16'h00AB, 16'h00C4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_wide = 0;
  logic spi_sck = 0, spi_ss_n = 1, spi_mosi = 0;
  logic spi_miso, spi_miso_oe;
  logic tx_valid = 0, tx_ready, rx_valid, rx_ready = 0, irq, irq_clr = 0, overrun;
  logic [15:0] tx_data = '0, rx_data, got;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_target_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_wide(cfg_wide), .spi_sck(spi_sck), .spi_ss_n(spi_ss_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq(irq), .irq_clr(irq_clr), .overrun(overrun)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic wd);
    cfg_cpol = pol; cfg_cpha = pha; cfg_wide = wd; spi_sck = pol;
    wait_n(4);
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk); tx_data = d; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic select();
    @(negedge clk); spi_ss_n = 1'b0; wait_n(8);
  endtask

  task automatic release_sel();
    @(negedge clk); spi_ss_n = 1'b1; wait_n(8);
  endtask

  // master model: shifts n bits of mw MSB first, returns the MISO bits
  task automatic shift_word(input logic [15:0] mw, input int n, output logic [15:0] rd);
    rd = '0;
    for (int i = n - 1; i >= 0; i--) begin
      if (!cfg_cpha) begin
        spi_mosi = mw[i]; wait_n(H);
        spi_sck = ~cfg_cpol; rd[i] = spi_miso; wait_n(H);
        spi_sck = cfg_cpol;
      end else begin
        spi_sck = ~cfg_cpol; spi_mosi = mw[i]; wait_n(H);
        spi_sck = cfg_cpol; rd[i] = spi_miso; wait_n(H);
      end
    end
    wait_n(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(5); rst_n = 1'b1; wait_n(2);
    // R12 reset state
    check("R12 rx_valid", {15'd0, rx_valid}, 16'd0);
    check("R12 irq", {15'd0, irq}, 16'd0);
    check("R12 overrun", {15'd0, overrun}, 16'd0);
    check("R12 tx_ready", {15'd0, tx_ready}, 16'd1);
    check("R12 miso_oe", {15'd0, spi_miso_oe}, 16'd0);

    // table walk: R1 R2 R3 R4 R5
    foreach (VECS[k]) begin
      set_mode(VECS[k].cpol, VECS[k].cpha, VECS[k].wide);
      push(VECS[k].stx);
      select();
      shift_word(VECS[k].mtx, VECS[k].wide ? 16 : 8, got);
      check($sformatf("R1/R2/R3 miso word vec%0d", k), got, VECS[k].exp_miso);
      check($sformatf("R1/R4 rx_data vec%0d", k), rx_data, VECS[k].exp_rx);
      check($sformatf("R5 rx_valid vec%0d", k), {15'd0, rx_valid}, 16'd1);
      check($sformatf("R5 irq vec%0d", k), {15'd0, irq}, 16'd1);
      release_sel();
      pop();
      check("R5 rx_valid after pop", {15'd0, rx_valid}, 16'd0);
      check("R5 irq kept after pop", {15'd0, irq}, 16'd1);
      clear_flags();
      check("R5 irq cleared", {15'd0, irq}, 16'd0);
    end

    // R6: activity without select
    set_mode(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      spi_mosi = 1'b1; spi_sck = 1'b1; wait_n(H); spi_sck = 1'b0; wait_n(H);
    end
    wait_n(4);
    check("R6 no rx_valid", {15'd0, rx_valid}, 16'd0);
    check("R6 no irq", {15'd0, irq}, 16'd0);
    check("R9 oe low unselected", {15'd0, spi_miso_oe}, 16'd0);
    push(16'h0069);
    select();
    shift_word(16'h0096, 8, got);
    check("R6 clean word after idle clocks", rx_data, 16'h0096);
    release_sel(); pop(); clear_flags();

    // R7: abort mid-word
    push(16'h00FF);
    select();
    shift_word(16'h0005, 3, got);
    release_sel();
    check("R7 no rx_valid after abort", {15'd0, rx_valid}, 16'd0);
    check("R7 no irq after abort", {15'd0, irq}, 16'd0);
    push(16'h0033);
    select();
    shift_word(16'h005A, 8, got);
    check("R7 restart rx", rx_data, 16'h005A);
    check("R7 restart miso", got, 16'h0033);
    release_sel(); pop(); clear_flags();

    // R8 / R9: when the holding word is taken
    set_mode(1'b0, 1'b1, 1'b0);
    push(16'h0080);
    select();
    check("R9 oe high selected", {15'd0, spi_miso_oe}, 16'd1);
    check("R8 cpha1 not taken at select", {15'd0, tx_ready}, 16'd0);
    spi_sck = 1'b1; spi_mosi = 1'b0; wait_n(H);
    check("R8 cpha1 first bit after edge", {15'd0, spi_miso}, 16'd1);
    check("R8 cpha1 taken at edge", {15'd0, tx_ready}, 16'd1);
    release_sel();
    spi_sck = 1'b0;
    check("R9 oe low released", {15'd0, spi_miso_oe}, 16'd0);
    check("R9 miso low released", {15'd0, spi_miso}, 16'd0);
    set_mode(1'b0, 1'b0, 1'b0);
    push(16'h0080);
    select();
    check("R8 cpha0 taken at select", {15'd0, tx_ready}, 16'd1);
    check("R8 cpha0 first bit at select", {15'd0, spi_miso}, 16'd1);
    release_sel();
    check("R7 R8 partial frames left no word", {15'd0, rx_valid}, 16'd0);

    // R11: back-to-back words and empty holding
    push(16'h0011);
    select();
    push(16'h0022);
    check("R11 ready low while full", {15'd0, tx_ready}, 16'd0);
    shift_word(16'h00A1, 8, got);
    check("R11 first word out", got, 16'h0011);
    check("R11 first word in", rx_data, 16'h00A1);
    pop();
    shift_word(16'h00B2, 8, got);
    check("R11 second word out", got, 16'h0022);
    check("R11 second word in", rx_data, 16'h00B2);
    pop();
    shift_word(16'h00C3, 8, got);
    check("R11 empty holding sends zeros", got, 16'h0000);
    release_sel(); pop(); clear_flags();

    // R10: overrun
    set_mode(1'b0, 1'b1, 1'b0);
    select();
    shift_word(16'h003C, 8, got);
    shift_word(16'h00C3, 8, got);
    release_sel();
    check("R10 overrun set", {15'd0, overrun}, 16'd1);
    check("R10 old word kept", rx_data, 16'h003C);
    check("R10 still full", {15'd0, rx_valid}, 16'd1);
    clear_flags();
    check("R10 overrun cleared", {15'd0, overrun}, 16'd0);
    pop();
    check("R10 buffer drained", {15'd0, rx_valid}, 16'd0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule